// File: doc/BRIEF.md
# Exception Acceptance Gate

This block sits between the decode stage and the exception sequencer of a small in-order processor. Each cycle it sees whether a decode is taking place and which class the decoded instruction belongs to. It also sees request pulses from two exception sources: an address-error detector and an external interrupt line. Every request pulse is latched in a pending bit. At each decode boundary the gate decides whether a pending exception may be taken there, or whether it must wait.

Two kinds of boundary are restricted. The first is the boundary just after an instruction with a delay slot. The branch and the slot instruction must run back to back, so neither source is taken there. The second is the boundary just after a transfer to or from a control or system register. There only the interrupt is held back, and the address error may still be taken.

The gate keeps the class of the last valid decode, so the next decode knows which restriction applies. A held request is never dropped. It is taken at the first later decode that permits its source. When the gate takes a request, it raises a strobe and names the source, and the sequencer acts on that.

Top module: `exc_gate_top`

## Requirements
- R1: `dec_class` encodes the decoded instruction as follows: 2'b00 plain, 2'b01 branch with a delay slot, 2'b10 control/system register transfer. 2'b11 is reserved and behaves exactly as plain.
- R2: A pulse on `addr_err_req` or `irq_req` sets that source's pending bit at the next clock edge. Acceptance looks only at stored pending bits, so a request is taken no earlier than the cycle after its pulse. `take_o`/`take_src` are combinational from the stored state and the current `dec_valid`.
- R3: In a valid decode whose previous valid decode was class 2'b01, nothing is taken, even when both sources are pending.
- R4: In a valid decode whose previous valid decode was class 2'b10, a pending interrupt is not taken, but a pending address error is taken.
- R5: A request that is held back stays pending and is taken at the first later valid decode that permits its source.
- R6: When both sources are pending and both are permitted, the address error is taken and the interrupt stays pending for a later decode.
- R7: A take clears that source's pending bit at the clock edge. A new request of the same source in that same cycle leaves the bit set, and the source is taken again at a later decode.
- R8: While `dec_valid` is low, nothing is taken and the remembered previous class does not change. Requests are still latched.
- R9: After reset both pending bits are clear, the previous class is plain and `take_o` is low.
- R10: `take_src` is 2'b00 with no take, 2'b01 for an address error and 2'b10 for an interrupt. `take_o` is high exactly when `take_src` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dec_valid | input | 1 | A decode boundary occurs this cycle |
| dec_class | input | 2 | Class of the instruction being decoded |
| addr_err_req | input | 1 | Address-error request pulse |
| irq_req | input | 1 | Interrupt request pulse |
| take_o | output | 1 | An exception is accepted this cycle |
| take_src | output | 2 | Source of the accepted exception |

## Verification
The gate's state is small: two pending bits and the remembered class. A wrong value in any of them shows at the ports within a few decodes. A lost pending bit shows as a take that never comes. A bit that is not cleared shows as a second take of the same source at the next permitted decode. A wrong remembered class shows as a take inside a delay slot, or as a take withheld at a plain boundary. The bench models each cycle from the requirements and compares `take_o` and `take_src` on every cycle. A fault therefore shows at the first decode where the correct and faulty states disagree.

// File: rtl/exc_gate_pkg.sv
package exc_gate_pkg;

  localparam int unsigned CLS_W  = 2;
  localparam int unsigned NSRC   = 2;
  localparam int unsigned SRC_W  = 2;

  // index order is priority order: lower index wins
  localparam int unsigned IDX_ADDR = 0;
  localparam int unsigned IDX_IRQ  = 1;

  typedef enum logic [CLS_W-1:0] {
    CLS_PLAIN  = 2'b00,
    CLS_DSLOT  = 2'b01,
    CLS_CREG   = 2'b10,
    CLS_RSVD   = 2'b11
  } icls_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 2'b00,
    SRC_ADDR = 2'b01,
    SRC_IRQ  = 2'b10
  } esrc_e;

  function automatic icls_e norm_cls(input logic [CLS_W-1:0] c);
    icls_e r;
    case (c)
      2'b01:   r = CLS_DSLOT;
      2'b10:   r = CLS_CREG;
      default: r = CLS_PLAIN;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/exc_pend_store.sv
module exc_pend_store
  import exc_gate_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pend_d[i] = set_i[i] | (pend_q[i] & ~clr_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !clr_i[g]) |=> pend_q[g]);  // R5
    AST_CLEAR_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !pend_q[g]);  // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_q[g]);                  // R7
  end

endmodule

// File: rtl/exc_slot_track.sv
module exc_slot_track
  import exc_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [CLS_W-1:0] dec_class,
  output icls_e            slot_o
);

  icls_e slot_q;
  icls_e slot_d;

  always_comb begin
    slot_d = slot_q;
    if (dec_valid) slot_d = norm_cls(dec_class);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= CLS_PLAIN;
    else        slot_q <= slot_d;
  end

  assign slot_o = slot_q;

  AST_IDLE_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> $stable(slot_q));   // R8
  AST_NO_RSVD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q != CLS_RSVD);               // R1

endmodule

// File: rtl/exc_accept_arb.sv
module exc_accept_arb
  import exc_gate_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         dec_valid,
  input  icls_e        slot_i,
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] grant_o,
  output esrc_e        src_o
);

  logic [N-1:0] allow;
  logic [N-1:0] elig;
  logic [N:0]   taken_lower;

  always_comb begin
    allow           = '0;
    allow[IDX_ADDR] = (slot_i != CLS_DSLOT);
    allow[IDX_IRQ]  = (slot_i == CLS_PLAIN);
    elig            = pend_i & allow & {N{dec_valid}};
  end

  // fixed priority: a source is granted when no lower index is eligible
  assign taken_lower[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_pri
    assign grant_o[g]       = elig[g] & ~taken_lower[g];
    assign taken_lower[g+1] = taken_lower[g] | elig[g];
  end

  always_comb begin
    src_o = SRC_NONE;
    if (grant_o[IDX_ADDR])     src_o = SRC_ADDR;
    else if (grant_o[IDX_IRQ]) src_o = SRC_IRQ;
  end

endmodule

// File: rtl/exc_gate_top.sv
module exc_gate_top
  import exc_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [CLS_W-1:0] dec_class,
  input  logic             addr_err_req,
  input  logic             irq_req,
  output logic             take_o,
  output logic [SRC_W-1:0] take_src
);

  logic [NSRC-1:0] req_vec;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] grant;
  icls_e           slot;
  esrc_e           src;

  always_comb begin
    req_vec           = '0;
    req_vec[IDX_ADDR] = addr_err_req;
    req_vec[IDX_IRQ]  = irq_req;
  end

  exc_pend_store #(.N(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (req_vec),
    .clr_i  (grant),
    .pend_o (pend)
  );

  exc_slot_track u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .dec_class (dec_class),
    .slot_o    (slot)
  );

  exc_accept_arb #(.N(NSRC)) u_arb (
    .dec_valid (dec_valid),
    .slot_i    (slot),
    .pend_i    (pend),
    .grant_o   (grant),
    .src_o     (src)
  );

  assign take_o   = |grant;
  assign take_src = src;

  AST_NONE_IN_DSLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == CLS_DSLOT) |-> !take_o);                          // R3
  AST_NO_IRQ_AFTER_CREG: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == CLS_CREG) |-> (take_src != SRC_IRQ));             // R4
  AST_NO_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !take_o);                                   // R8
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));                                          // R10
  AST_ADDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && pend[IDX_ADDR]) |-> (take_src == SRC_ADDR));    // R6
  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (pend != '0));                                  // R2

endmodule

// File: tb/sim_exc_gate_top.sv
module sim_exc_gate_top;

  localparam int PERIOD = 20;
  localparam int LIMIT  = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dec_valid;
  logic [1:0] dec_class;
  logic       addr_err_req;
  logic       irq_req;
  logic       take_o;
  logic [1:0] take_src;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  int m_ae;
  int m_irq;
  int m_prev;

  always #(PERIOD/2) clk = ~clk;

  exc_gate_top u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_valid    (dec_valid),
    .dec_class    (dec_class),
    .addr_err_req (addr_err_req),
    .irq_req      (irq_req),
    .take_o       (take_o),
    .take_src     (take_src)
  );

  task automatic cyc(input bit v, input int cls, input bit ae, input bit iq, input string tag);
    int exp_src;
    bit exp_take;
    @(negedge clk);
    dec_valid    = v;
    dec_class    = cls[1:0];
    addr_err_req = ae;
    irq_req      = iq;
    #2;
    exp_src = 0;
    if (v) begin
      if (m_ae != 0 && m_prev != 1)       exp_src = 1;
      else if (m_irq != 0 && m_prev == 0) exp_src = 2;
    end
    exp_take = (exp_src != 0);
    total++;
    if (take_o !== exp_take || take_src !== exp_src[1:0]) begin
      bad++;
      $display("FAIL %s: take=%b src=%0d expected take=%b src=%0d",
               tag, take_o, take_src, exp_take, exp_src);
    end
    // model the following clock edge
    m_ae  = (ae  || (m_ae  != 0 && exp_src != 1)) ? 1 : 0;
    m_irq = (iq  || (m_irq != 0 && exp_src != 2)) ? 1 : 0;
    if (v) m_prev = (cls == 3) ? 0 : cls;
  endtask

  initial begin
    #(PERIOD * LIMIT);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    dec_valid = 1'b0; dec_class = 2'b00; addr_err_req = 1'b0; irq_req = 1'b0;
    m_ae = 0; m_irq = 0; m_prev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: idle after reset, then a valid plain decode takes nothing
    cyc(0, 0, 0, 0, "R9");
    cyc(1, 0, 0, 0, "R9");
    // R2: request is stored first, taken on the next decode
    cyc(1, 0, 1, 0, "R2");
    cyc(1, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, "R2");
    // R3: both pending, slot after delayed branch blocks both
    cyc(1, 1, 1, 1, "R3");
    cyc(1, 0, 0, 0, "R3");
    // R5 + R6: address error first, interrupt after
    cyc(1, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, "R5");
    cyc(1, 0, 0, 0, "R5");
    // R4: after a control-register transfer, address error yes, interrupt no
    cyc(1, 2, 1, 1, "R4");
    cyc(1, 0, 0, 0, "R4");
    cyc(1, 2, 0, 0, "R4");
    cyc(1, 0, 0, 0, "R4");
    cyc(1, 0, 0, 0, "R5");
    // R8: idle cycles do not take and do not touch the previous class
    cyc(1, 1, 0, 1, "R8");
    cyc(0, 0, 0, 0, "R8");
    cyc(0, 2, 0, 0, "R8");
    cyc(1, 0, 0, 0, "R8");
    cyc(1, 0, 0, 0, "R8");
    // R7: new request on the take cycle keeps the bit set
    cyc(1, 0, 1, 0, "R7");
    cyc(1, 0, 1, 0, "R7");
    cyc(1, 0, 0, 0, "R7");
    cyc(1, 0, 0, 0, "R7");
    // R1: reserved class behaves as plain
    cyc(1, 3, 0, 1, "R1");
    cyc(1, 3, 0, 0, "R1");
    cyc(1, 0, 0, 0, "R1");

    // R10: mixed stimulus against the model
    for (int k = 0; k < 3000; k++) begin
      cyc(($urandom % 4) != 0, $urandom % 4,
          ($urandom % 5) == 0, ($urandom % 4) == 0, "R10");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule